// File: doc/BRIEF.md
# Periodic Down-Counter Timer Channel

This block is one timer channel. Software sets it up through three 32-bit registers on a simple bus: a configuration register, a status register and a tick-source select register. When software enables the channel, it loads a programmed reload value and counts down by one on each pulse of the selected tick input. The tick inputs are generated outside the block; the first one is the microsecond tick.

When a tick arrives while the count is zero, the channel expires. It drives a one-cycle expiry pulse, which a neighbouring watchdog can count, and it sets a sticky pending flag that is driven out as the interrupt. In periodic mode the count returns to the reload value on that same tick. In one-shot mode the channel disables itself and the count stays at zero. One period therefore lasts reload + 1 ticks.

The bus is a single-cycle write strobe with a combinational read. Addresses are byte offsets, and only word-aligned offsets decode. The asynchronous active-low reset is released to the logic through a two-stage synchronizer.

Top module: `tmr_channel`

## Requirements
- R1: After reset, every register reads zero, `irq_o` is low and `expire_o` is low.
- R2: The configuration register is at offset 0x0. Bit 31 is enable, bit 30 selects periodic mode, and bits [27:0] hold the reload value. Bits 29:28 always read zero.
- R3: A configuration write that raises enable from 0 to 1 loads the reload value into the counter. A write that leaves enable at 1 does not reload the counter. The status register at offset 0x4 returns the live count in bits [28:0].
- R4: While the channel is enabled, each selected tick lowers a non-zero count by one. While it is disabled, ticks are ignored and the count holds.
- R5: A selected tick at count zero produces a one-cycle `expire_o` pulse and sets the sticky pending flag. In periodic mode the count reloads on that same tick.
- R6: In one-shot mode (bit 30 = 0), expiry clears the enable bit, so configuration bit 31 then reads 0 and the count stays at zero.
- R7: Status bit 30 reads the pending flag, which is also driven on `irq_o`. A status write with bit 30 = 1 clears the flag. A status write with bit 30 = 0 leaves it set.
- R8: When a clear write and an expiry fall in the same cycle, the clear wins: the flag is low afterwards, but the expiry pulse is still produced.
- R9: The select register at offset 0x8 holds a 4-bit field in bits [3:0]. Value k selects `tick_src[k]`, and value 0 selects the microsecond tick. Unselected ticks have no effect, and a value with no matching source selects no tick.
- R10: Writing 0 to the configuration register stops the channel. The count then holds through later ticks, and no expiry occurs.
- R11: Offsets 0xC and any offset that is not word-aligned read zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick_src | input | NUM_SRC | Tick pulses, one per source; index 0 is the microsecond tick |
| expire_o | output | 1 | One-cycle pulse on each expiry |
| irq_o | output | 1 | Sticky pending flag |

## Verification
Two events can land in the same cycle: software clearing the pending flag, and an expiry setting it. The bench provokes this by running a periodic channel with reload zero, so that every tick expires. It then asserts a tick and a clear write together on one edge. The bench expects `irq_o` low and `expire_o` high after that edge, and the flag set again by the next tick alone. A second coincidence, a configuration write against a tick, is kept out of the directed runs and is covered by the one-shot assertion, which excludes write cycles.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 4;
  localparam int RELOAD_W = 28;
  localparam int COUNT_W  = 29;
  localparam int SEL_W    = 4;

  // word index decoded from bus_addr[3:2]
  localparam logic [1:0] W_CFG  = 2'd0;
  localparam logic [1:0] W_STAT = 2'd1;
  localparam logic [1:0] W_SEL  = 2'd2;

  localparam int B_EN  = 31;
  localparam int B_PER = 30;
  localparam int B_PND = 30;
endpackage

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel #(
  parameter int NUM_SRC = 4,
  parameter int SEL_W   = 4
) (
  input  logic [NUM_SRC-1:0] tick_src,
  input  logic [SEL_W-1:0]   sel,
  output logic               tick
);
  logic [NUM_SRC-1:0] hit;

  // an out-of-range select matches no source
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign hit[i] = (sel == SEL_W'(i)) && tick_src[i];
  end

  assign tick = |hit;
endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [RELOAD_W-1:0] load_val,
  input  logic [RELOAD_W-1:0] reload,
  input  logic                periodic,
  input  logic                run,
  input  logic                tick,
  output logic [COUNT_W-1:0]  count,
  output logic                expire_evt,
  output logic                expire_q
);
  logic [COUNT_W-1:0] cnt_q, cnt_d;
  logic               exp_d;
  logic               at_zero;

  assign at_zero    = (cnt_q == '0);
  assign expire_evt = run && tick && at_zero && !load;

  always_comb begin
    cnt_d = cnt_q;
    exp_d = 1'b0;
    if (load) begin
      cnt_d = COUNT_W'(load_val);
    end else if (run && tick) begin
      if (at_zero) begin
        exp_d = 1'b1;
        cnt_d = periodic ? COUNT_W'(reload) : '0;
      end else begin
        cnt_d = cnt_q - COUNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      expire_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      expire_q <= exp_d;
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [COUNT_W-1:0]  count,
  input  logic                expire_evt,
  output logic                cfg_en,
  output logic                cfg_per,
  output logic [RELOAD_W-1:0] cfg_reload,
  output logic [SEL_W-1:0]    sel,
  output logic                load,
  output logic                run,
  output logic                pending
);
  logic                aligned;
  logic                wr_cfg, wr_stat, wr_sel;
  logic                en_q, en_d, per_q, per_d, pnd_q, pnd_d;
  logic [RELOAD_W-1:0] rld_q, rld_d;
  logic [SEL_W-1:0]    sel_q, sel_d;
  logic                unused_wbits;

  assign unused_wbits = ^bus_wdata[29:28];

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr_cfg  = bus_we && aligned && (bus_addr[3:2] == W_CFG);
  assign wr_stat = bus_we && aligned && (bus_addr[3:2] == W_STAT);
  assign wr_sel  = bus_we && aligned && (bus_addr[3:2] == W_SEL);

  // a config write takes precedence over a tick in the same cycle
  assign load = wr_cfg && bus_wdata[B_EN] && !en_q;
  assign run  = en_q && !wr_cfg;

  always_comb begin
    en_d  = en_q;
    per_d = per_q;
    rld_d = rld_q;
    sel_d = sel_q;
    pnd_d = pnd_q;
    if (wr_cfg) begin
      en_d  = bus_wdata[B_EN];
      per_d = bus_wdata[B_PER];
      rld_d = bus_wdata[RELOAD_W-1:0];
    end else if (expire_evt && !per_q) begin
      en_d = 1'b0;
    end
    if (wr_sel) sel_d = bus_wdata[SEL_W-1:0];
    if (expire_evt) pnd_d = 1'b1;
    if (wr_stat && bus_wdata[B_PND]) pnd_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      per_q <= 1'b0;
      rld_q <= '0;
      sel_q <= '0;
      pnd_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      per_q <= per_d;
      rld_q <= rld_d;
      sel_q <= sel_d;
      pnd_q <= pnd_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      case (bus_addr[3:2])
        W_CFG:   bus_rdata = {en_q, per_q, 2'b00, rld_q};
        W_STAT:  bus_rdata = {1'b0, pnd_q, 1'b0, count};
        W_SEL:   bus_rdata = {{(DATA_W-SEL_W){1'b0}}, sel_q};
        default: bus_rdata = '0;
      endcase
    end
  end

  assign cfg_en     = en_q;
  assign cfg_per    = per_q;
  assign cfg_reload = rld_q;
  assign sel        = sel_q;
  assign pending    = pnd_q;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [3:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_SRC-1:0] tick_src,
  output logic               expire_o,
  output logic               irq_o
);
  logic [1:0]          rst_sync;
  logic                rst_core_n;
  logic                cfg_en, cfg_per, load, run, tick, expire_evt;
  logic [RELOAD_W-1:0] cfg_reload;
  logic [SEL_W-1:0]    sel;
  logic [COUNT_W-1:0]  count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  tmr_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .count      (count),
    .expire_evt (expire_evt),
    .cfg_en     (cfg_en),
    .cfg_per    (cfg_per),
    .cfg_reload (cfg_reload),
    .sel        (sel),
    .load       (load),
    .run        (run),
    .pending    (irq_o)
  );

  tmr_tick_sel #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_sel (
    .tick_src (tick_src),
    .sel      (sel),
    .tick     (tick)
  );

  tmr_count u_cnt (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .load       (load),
    .load_val   (bus_wdata[RELOAD_W-1:0]),
    .reload     (cfg_reload),
    .periodic   (cfg_per),
    .run        (run),
    .tick       (tick),
    .count      (count),
    .expire_evt (expire_evt),
    .expire_q   (expire_o)
  );
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk
  import tmr_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                bus_we,
  input logic [3:0]          bus_addr,
  input logic                wr_b30,
  input logic                irq,
  input logic                expire,
  input logic                en_q,
  input logic                per_q,
  input logic [RELOAD_W-1:0] reload_q,
  input logic [COUNT_W-1:0]  count
);
  logic wr_cfg, clr_stat;
  assign wr_cfg   = bus_we && (bus_addr == 4'h0);
  assign clr_stat = bus_we && (bus_addr == 4'h4) && wr_b30;

  // R3: a fresh enable leaves the counter holding the reload value
  a_r3_load_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> (count == {1'b0, reload_q}));

  // R4: a disabled channel holds its count
  a_r4_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wr_cfg) |=> $stable(count));

  // R5: the pending flag only rises together with an expiry pulse
  a_r5_flag_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> expire);

  // R6: one-shot expiry turns the channel off
  a_r6_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !per_q && !$past(wr_cfg)) |-> !en_q);

  // R7: the flag stays set until a clear write
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_stat) |=> irq);

  // R8: a clear write always leaves the flag low
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stat |=> !irq);
endmodule

bind tmr_channel tmr_channel_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .wr_b30   (bus_wdata[30]),
  .irq      (irq_o),
  .expire   (expire_o),
  .en_q     (cfg_en),
  .per_q    (cfg_per),
  .reload_q (cfg_reload),
  .count    (count)
);

// File: tb/sim_tmr_channel.sv
`timescale 1ns/1ps
module sim_tmr_channel;
  localparam int NSRC = 4;

  logic            clk, rst_n, bus_we;
  logic [3:0]      bus_addr;
  logic [31:0]     bus_wdata, bus_rdata, rd;
  logic [NSRC-1:0] tick_src;
  logic            expire_o, irq_o;
  int              n_chk, n_fail, n_pulse, base;
  bit              done;

  tmr_channel #(.NUM_SRC(NSRC)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_src(tick_src),
    .expire_o(expire_o), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial n_pulse = 0;
  always @(negedge clk) if (expire_o) n_pulse = n_pulse + 1;

  typedef struct packed {
    logic [27:0] reload;
    logic        per;
    logic [7:0]  nt;
    logic [28:0] cnt;
    logic        irq;
    logic        en;
    logic [7:0]  pulses;
  } vec_t;

  // reload, periodic, ticks -> count, flag, enable, expiry pulses
  localparam vec_t VECS [8] = '{
    '{28'd5,  1'b0, 8'd3,  29'd2,  1'b0, 1'b1, 8'd0},
    '{28'd5,  1'b0, 8'd6,  29'd0,  1'b1, 1'b0, 8'd1},
    '{28'd5,  1'b1, 8'd6,  29'd5,  1'b1, 1'b1, 8'd1},
    '{28'd3,  1'b1, 8'd9,  29'd2,  1'b1, 1'b1, 8'd2},
    '{28'd0,  1'b1, 8'd2,  29'd0,  1'b1, 1'b1, 8'd2},
    '{28'd0,  1'b0, 8'd1,  29'd0,  1'b1, 1'b0, 8'd1},
    '{28'd10, 1'b0, 8'd10, 29'd0,  1'b0, 1'b1, 8'd0},
    '{28'd5,  1'b0, 8'd8,  29'd0,  1'b1, 1'b0, 8'd1}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rdreg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic ticks(input int src, input int n);
    if (n > 0) begin
      @(negedge clk);
      tick_src[src] = 1'b1;
      repeat (n) @(negedge clk);
      tick_src[src] = 1'b0;
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; tick_src = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rdreg(4'h0, rd); check(rd == 0, "R1 cfg", rd, 0);
    rdreg(4'h4, rd); check(rd == 0, "R1 status", rd, 0);
    rdreg(4'h8, rd); check(rd == 0, "R1 select", rd, 0);
    check(irq_o == 0 && expire_o == 0, "R1 outputs", {irq_o, expire_o}, 0);
    // R11 unmapped offset
    rdreg(4'hC, rd); check(rd == 0, "R11 offset 0xC", rd, 0);

    // vector table
    for (int i = 0; i < 8; i++) begin
      wr(4'h0, 32'h0);
      wr(4'h4, 32'h4000_0000);
      wr(4'h0, {1'b1, VECS[i].per, 2'b00, VECS[i].reload});
      base = n_pulse;
      ticks(0, int'(VECS[i].nt));
      rdreg(4'h4, rd);
      check(rd[28:0] == VECS[i].cnt, $sformatf("R4 R5 vec%0d count", i),
            32'(rd[28:0]), 32'(VECS[i].cnt));
      check(rd[30] == VECS[i].irq && irq_o == VECS[i].irq,
            $sformatf("R7 vec%0d flag", i), {rd[30], irq_o}, {2{VECS[i].irq}});
      rdreg(4'h0, rd);
      check(rd[31] == VECS[i].en, $sformatf("R6 vec%0d enable", i),
            32'(rd[31]), 32'(VECS[i].en));
      check(n_pulse - base == int'(VECS[i].pulses), $sformatf("R5 vec%0d pulses", i),
            32'(n_pulse - base), 32'(VECS[i].pulses));
    end

    // R7: a write of 0 keeps the flag, a write of bit 30 clears it
    wr(4'h4, 32'h0);
    rdreg(4'h4, rd); check(rd[30] == 1 && irq_o == 1, "R7 zero write keeps", 32'(rd[30]), 1);
    wr(4'h4, 32'h4000_0000);
    rdreg(4'h4, rd); check(rd[30] == 0 && irq_o == 0, "R7 clear", 32'(rd[30]), 0);

    // R2 layout, bits 29:28 dropped
    wr(4'h0, 32'h0);
    wr(4'h0, 32'h7FFF_FFFF);
    rdreg(4'h0, rd); check(rd == 32'h4FFF_FFFF, "R2 readback", rd, 32'h4FFF_FFFF);
    wr(4'h0, 32'h0);

    // R3 load on enable, full 28-bit reload
    wr(4'h0, 32'hBFFF_FFFF);
    rdreg(4'h0, rd); check(rd == 32'h8FFF_FFFF, "R2 enabled readback", rd, 32'h8FFF_FFFF);
    rdreg(4'h4, rd); check(rd == 32'h0FFF_FFFF, "R3 load", rd, 32'h0FFF_FFFF);
    ticks(0, 2);
    rdreg(4'h4, rd); check(rd == 32'h0FFF_FFFD, "R4 decrement", rd, 32'h0FFF_FFFD);
    wr(4'h0, 32'h8000_0005);
    rdreg(4'h4, rd); check(rd == 32'h0FFF_FFFD, "R3 no reload while on", rd, 32'h0FFF_FFFD);

    // R10 stop by writing zero
    wr(4'h0, 32'h0);
    base = n_pulse;
    ticks(0, 3);
    rdreg(4'h4, rd); check(rd == 32'h0FFF_FFFD, "R10 count holds", rd, 32'h0FFF_FFFD);
    check(n_pulse == base, "R10 no expiry", 32'(n_pulse - base), 0);

    // R9 source select
    wr(4'h0, 32'h8000_0007);
    wr(4'h8, 32'h1);
    ticks(0, 3);
    rdreg(4'h4, rd); check(rd == 7, "R9 unselected ignored", rd, 7);
    ticks(1, 2);
    rdreg(4'h4, rd); check(rd == 5, "R9 source 1 counts", rd, 5);
    wr(4'h8, 32'h5);
    rdreg(4'h8, rd); check(rd == 5, "R9 select readback", rd, 5);
    ticks(1, 2); ticks(3, 2); ticks(0, 2);
    rdreg(4'h4, rd); check(rd == 5, "R9 out of range selects none", rd, 5);
    wr(4'h8, 32'h0);

    // R11 misaligned write ignored
    wr(4'h1, 32'h0);
    rdreg(4'h0, rd); check(rd == 32'h8000_0007, "R11 misaligned write", rd, 32'h8000_0007);
    rdreg(4'h2, rd); check(rd == 0, "R11 misaligned read", rd, 0);

    // R8 clear and expiry in the same cycle
    wr(4'h0, 32'h0);
    wr(4'h0, 32'hC000_0000);
    ticks(0, 1);
    check(irq_o == 1, "R5 flag set", 32'(irq_o), 1);
    @(negedge clk);
    tick_src[0] = 1'b1; bus_we = 1'b1; bus_addr = 4'h4; bus_wdata = 32'h4000_0000;
    @(negedge clk);
    tick_src[0] = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    #1;
    check(irq_o == 0, "R8 clear wins", 32'(irq_o), 0);
    check(expire_o == 1, "R8 pulse still made", 32'(expire_o), 1);
    ticks(0, 1);
    check(irq_o == 1, "R8 next expiry sets", 32'(irq_o), 1);

    done = 1;
    summary();
    $finish;
  end
endmodule